// File: doc/BRIEF.md
# Prioritized Two-Source Interrupt Controller

This block decides when the processor core takes an interrupt. Requests come from two asynchronous external pins and from a timer/counter overflow strobe. Each pin passes through a synchronizer and a rising-edge detector. A detected edge latches an input request and sets that pin's mask flag. Overflows set a timer flag and latch a separate timer request. A global enable gates acceptance. When both requests are pending, the input request wins and the timer request stays pending until later.

Acceptance shows as a one-cycle take strobe that carries a fixed vector address. On that clock edge the block clears the enable, clears the served request and pushes `pc_in` onto a shift-style return stack. The stack has four levels. The core also drives a normal call push, a normal return and an interrupt return through single-cycle strobes. The interrupt return also sets the enable again. Software clears mask flags and the timer flag through clear strobes. Each flag and each pin level can be read on a status vector.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A low-to-high change on `pin_a` or `pin_b` that is held at least two cycles sets the input request (`status[5]`) and that pin's mask (`status[2]` for a, `status[3]` for b) on the third rising clock edge after the change. The synchronized levels show on `status[0]` (a) and `status[1]` (b).
- R2: While a pin's mask is set, a rising edge on that pin raises no request. `clr_mask_a`/`clr_mask_b` clear the mask, and after that a new edge raises a request again.
- R3: While the enable (`status[7]`) is 0, a latched request stays set for any number of cycles.
- R4: When the enable is 1 and a request is pending, `take` is high in that cycle. On the following edge the served request flag and the enable are both cleared.
- R5: If the input request and the timer request (`status[6]`) are both set, the input request is taken first. The timer request stays set and is taken once the enable returns to 1.
- R6: Mask flags and the timer flag (`status[4]`) are set-dominant. A clear strobe in the same cycle as an edge or overflow leaves the flag at 1, and the request is still latched.
- R7: `take_vec` is 0x07F (page 1, offset 0x3F) for an input interrupt and 0x03F (page 0, offset 0x3F) for a timer interrupt.
- R8: A take or `call_push` moves `pc_in` into level 1 and shifts the other levels down one place. The old level 4 is lost. `pc_out` shows level 1. A pop shifts the levels up and leaves level 4 unchanged. When a push and a pop come in the same cycle, the push wins.
- R9: `ret_pop` pops the stack and leaves the enable as it was. `reti_pop` pops the stack and sets the enable on the same edge. `set_ie`/`clr_ie` set and clear the enable directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_a | input | 1 | External interrupt pin A, asynchronous |
| pin_b | input | 1 | External interrupt pin B, asynchronous |
| tmr_ovf | input | 1 | Timer/counter overflow strobe |
| clr_mask_a | input | 1 | Clear mask flag of pin A |
| clr_mask_b | input | 1 | Clear mask flag of pin B |
| clr_tflag | input | 1 | Clear timer flag |
| set_ie | input | 1 | Set global enable |
| clr_ie | input | 1 | Clear global enable |
| call_push | input | 1 | Normal call: push `pc_in` |
| ret_pop | input | 1 | Normal return: pop |
| reti_pop | input | 1 | Interrupt return: pop and set enable |
| pc_in | input | PC_W | Address pushed on call or take |
| take | output | 1 | Interrupt accepted this cycle |
| take_vec | output | PC_W | Vector address of the accepted interrupt |
| pc_out | output | PC_W | Stack level 1 (return address) |
| status | output | 8 | {ie, timer req, input req, timer flag, mask b, mask a, level b, level a} |

## Verification
The stack runs first through a table of pushes and pops. The table pushes past full, which shows that the oldest entry is lost and that level 4 is copied on pops. It also shows that a normal return differs from an interrupt return only in the enable. Directed pin sequences then try four cases. A first edge with the enable low shows that the request is held. A second edge on a masked pin shows that it is suppressed. A steady pin after the mask is cleared shows that a level alone raises nothing. An edge that lands together with a mask clear shows set dominance. A timer overflow that is pending during an input take separates the two vectors and shows that the losing timer request is taken later.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int PC_W  = 10,
  parameter int OFS_W = 6,
  parameter int DEPTH = 4,
  parameter int SYNC  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pin_a,
  input  logic            pin_b,
  input  logic            tmr_ovf,
  input  logic            clr_mask_a,
  input  logic            clr_mask_b,
  input  logic            clr_tflag,
  input  logic            set_ie,
  input  logic            clr_ie,
  input  logic            call_push,
  input  logic            ret_pop,
  input  logic            reti_pop,
  input  logic [PC_W-1:0] pc_in,
  output logic            take,
  output logic [PC_W-1:0] take_vec,
  output logic [PC_W-1:0] pc_out,
  output logic [7:0]      status
);
  localparam int OFS_MAX = (1 << OFS_W) - 1;
  localparam logic [PC_W-1:0] TMR_VEC = PC_W'(OFS_MAX);
  localparam logic [PC_W-1:0] IN_VEC  = PC_W'((1 << OFS_W) + OFS_MAX);

  logic [SYNC:0] sh_a, sh_b;
  logic mask_a, mask_b, tflag, in_req, tm_req, ie;
  logic [PC_W-1:0] stk [DEPTH];

  wire lvl_a  = sh_a[SYNC-1];
  wire lvl_b  = sh_b[SYNC-1];
  wire edge_a = lvl_a & ~sh_a[SYNC];
  wire edge_b = lvl_b & ~sh_b[SYNC];
  wire in_set = (edge_a & ~mask_a) | (edge_b & ~mask_b);

  assign take     = ie & (in_req | tm_req);
  wire   take_in  = take & in_req;
  wire   take_tm  = take & ~in_req;
  assign take_vec = in_req ? IN_VEC : TMR_VEC;

  wire push = take | call_push;
  wire pop  = (ret_pop | reti_pop) & ~push;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_a <= '0;
      sh_b <= '0;
    end else begin
      sh_a <= {sh_a[SYNC-1:0], pin_a};
      sh_b <= {sh_b[SYNC-1:0], pin_b};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_a <= 1'b0;
      mask_b <= 1'b0;
      tflag  <= 1'b0;
      in_req <= 1'b0;
      tm_req <= 1'b0;
    end else begin
      mask_a <= edge_a | (mask_a & ~clr_mask_a);
      mask_b <= edge_b | (mask_b & ~clr_mask_b);
      tflag  <= tmr_ovf | (tflag & ~clr_tflag);
      in_req <= in_set | (in_req & ~take_in);
      tm_req <= tmr_ovf | (tm_req & ~take_tm);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                   ie <= 1'b0;
    else if (take)                ie <= 1'b0;
    else if (set_ie || reti_pop)  ie <= 1'b1;
    else if (clr_ie)              ie <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
    end else if (push) begin
      stk[0] <= pc_in;
      for (int i = 1; i < DEPTH; i++) stk[i] <= stk[i-1];
    end else if (pop) begin
      for (int i = 0; i < DEPTH-1; i++) stk[i] <= stk[i+1];
    end
  end

  assign pc_out = stk[0];
  assign status = {ie, tm_req, in_req, tflag, mask_b, mask_a, lvl_b, lvl_a};

  a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (in_req && !take) |=> in_req);
  a_r4_take_clears_ie: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !ie);
  a_r5_timer_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_req && tm_req) |=> tm_req);
  a_r6_mask_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_a && clr_mask_a) |=> mask_a);
  a_r6_tflag_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_ovf && clr_tflag) |=> (tflag && tm_req));
  a_r7_vec_offset: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (take_vec[OFS_W-1:0] == OFS_W'(OFS_MAX)));
  a_r8_push_top: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (pc_out == $past(pc_in)));
  a_r9_ret_keeps_ie: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_pop && !reti_pop && !take && !set_ie && !clr_ie) |=> $stable(ie));
  a_r9_reti_sets_ie: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_pop && !take) |=> ie);
endmodule

// File: tb/tb_irq_prio_ctrl.sv
`timescale 1ns/1ps
module tb_irq_prio_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_a = 0, pin_b = 0, tmr_ovf = 0, clr_mask_a = 0, clr_mask_b = 0, clr_tflag = 0;
  logic set_ie = 0, clr_ie = 0, call_push = 0, ret_pop = 0, reti_pop = 0;
  logic [9:0] pc_in = '0;
  logic take;
  logic [9:0] take_vec, pc_out;
  logic [7:0] status;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  irq_prio_ctrl dut (.clk(clk), .rst_n(rst_n), .pin_a(pin_a), .pin_b(pin_b), .tmr_ovf(tmr_ovf),
    .clr_mask_a(clr_mask_a), .clr_mask_b(clr_mask_b), .clr_tflag(clr_tflag), .set_ie(set_ie),
    .clr_ie(clr_ie), .call_push(call_push), .ret_pop(ret_pop), .reti_pop(reti_pop), .pc_in(pc_in),
    .take(take), .take_vec(take_vec), .pc_out(pc_out), .status(status));

  // {op(0 push,1 ret,2 reti), pc_in, expected pc_out, expected ie}
  localparam logic [22:0] TBL [11] = '{
    {2'd0, 10'h101, 10'h101, 1'b0}, {2'd0, 10'h102, 10'h102, 1'b0},
    {2'd0, 10'h103, 10'h103, 1'b0}, {2'd0, 10'h104, 10'h104, 1'b0},
    {2'd0, 10'h105, 10'h105, 1'b0}, {2'd1, 10'h000, 10'h104, 1'b0},
    {2'd1, 10'h000, 10'h103, 1'b0}, {2'd1, 10'h000, 10'h102, 1'b0},
    {2'd1, 10'h000, 10'h102, 1'b0}, {2'd0, 10'h200, 10'h200, 1'b0},
    {2'd2, 10'h000, 10'h102, 1'b1}
  };

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    repeat (3) cyc();
    rst_n = 1'b1;
    chk("reset status", status, 8'h00);
    chk("reset take", take, 0);
    chk("reset pc_out", pc_out, 0);

    // R8 / R9 stack table
    for (int i = 0; i < 11; i++) begin
      logic [22:0] e;
      e = TBL[i];
      pc_in = e[20:11];
      call_push = (e[22:21] == 2'd0);
      ret_pop   = (e[22:21] == 2'd1);
      reti_pop  = (e[22:21] == 2'd2);
      cyc();
      call_push = 0; ret_pop = 0; reti_pop = 0;
      chk("R8 stack pc_out", pc_out, e[10:1]);
      chk("R9 enable after pop", status[7], e[0]);
    end
    ret_pop = 1; cyc(); ret_pop = 0;
    chk("R9 ret keeps ie", status[7], 1);
    chk("R8 pop bottom copy", pc_out, 10'h102);
    clr_ie = 1; cyc(); clr_ie = 0;
    chk("R9 clr_ie", status[7], 0);

    // R1 edge detection with enable low
    pin_a = 1; cyc(); cyc();
    chk("R1 not yet latched", status[5], 0);
    cyc();
    chk("R1 status after edge a", status, 8'h25);
    repeat (5) cyc();
    chk("R3 request held", status[5], 1);
    chk("R3 no take with ie low", take, 0);

    // R4 / R7 input take
    pc_in = 10'h155; set_ie = 1; cyc(); set_ie = 0;
    chk("R4 take high", take, 1);
    chk("R7 input vector", take_vec, 10'h07F);
    cyc();
    chk("R4 request cleared", status[5], 0);
    chk("R4 ie cleared", status[7], 0);
    chk("R4 take dropped", take, 0);
    chk("R8 take pushes pc", pc_out, 10'h155);

    // R2 masking
    pin_a = 0; repeat (3) cyc();
    pin_a = 1; repeat (4) cyc();
    chk("R2 masked edge no request", status[5], 0);
    chk("R2 mask still set", status[2], 1);
    clr_mask_a = 1; cyc(); clr_mask_a = 0;
    chk("R2 mask cleared", status[2], 0);
    chk("R2 steady level no request", status[5], 0);
    pin_a = 0; repeat (3) cyc();
    pin_a = 1; repeat (3) cyc();
    chk("R2 edge after unmask", status[5], 1);
    chk("R2 mask set again", status[2], 1);

    // R5 priority
    tmr_ovf = 1; cyc(); tmr_ovf = 0;
    chk("R5 timer request", status[6], 1);
    chk("R6 timer flag set", status[4], 1);
    pc_in = 10'h0AA; set_ie = 1; cyc(); set_ie = 0;
    chk("R5 input first", take_vec, 10'h07F);
    chk("R5 take", take, 1);
    cyc();
    chk("R5 timer kept", status[6], 1);
    chk("R5 input served", status[5], 0);
    chk("R5 no take while ie low", take, 0);
    reti_pop = 1; cyc(); reti_pop = 0;
    chk("R9 reti sets ie", status[7], 1);
    chk("R9 reti popped", pc_out, 10'h155);
    chk("R5 timer taken later", take, 1);
    chk("R7 timer vector", take_vec, 10'h03F);
    cyc();
    chk("R5 timer served", status[6], 0);
    chk("R4 ie cleared timer", status[7], 0);

    // R6 set dominance
    pin_b = 1; cyc(); cyc();
    clr_mask_b = 1; cyc(); clr_mask_b = 0;
    chk("R6 mask b set wins", status[3], 1);
    chk("R6 request latched", status[5], 1);
    chk("R1 level b", status[1], 1);
    clr_tflag = 1; cyc(); clr_tflag = 0;
    chk("R6 tflag cleared", status[4], 0);
    tmr_ovf = 1; clr_tflag = 1; cyc(); tmr_ovf = 0; clr_tflag = 0;
    chk("R6 tflag set wins", status[4], 1);
    chk("R6 timer req latched", status[6], 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule